// File: doc/BRIEF.md
# Daylight Saving Time Adjuster

This block sits beside a BCD calendar counter and decides when the wall-clock hour must be shifted for daylight saving. It watches the current year, month, date, weekday, hour and minute. On each calendar tick it compares them with two programmed transition points. At the spring point it asks the calendar to move the hour forward by one. At the autumn point it asks for the hour to move back by one. A status flag shows whether the shifted time is currently in force.

Each transition point is set by four control bytes: a month, a day selector, a date and an hour. The day selector either picks a fixed calendar date or picks an occurrence of a weekday within the month, such as the second Sunday or the last Saturday. A priority bit in the selector byte chooses which of the two applies. A single master enable, kept in the forward month byte, gates the whole function. The calendar counter and the hour arithmetic are outside this block; it only issues one-cycle adjust commands.

A transition is honoured only if the block saw it coming. While enabled, it must have observed a tick at the top of an earlier hour on the transition day. Because the autumn move is allowed only while the status flag is set, and the move itself clears the flag, the repeated hour after falling back cannot trigger a second move.

Top module: `dst_adjuster`

## Requirements
- R1: While reset is asserted and after its release, `hour_inc`, `hour_dec` and `dst_active` are 0 until a transition fires.
- R2: The master enable is `fwd_month[7]`. When it is 1, the forward point is armed and `dst_active` is 0, a tick whose time matches the forward day at minute 00 of hour `fwd_hour` produces a one-cycle `hour_inc` pulse in the cycle after the tick. `dst_active` becomes 1 in the same cycle as the pulse.
- R3: When the reverse point is armed and `dst_active` is 1, a tick matching the reverse day at minute 00 of hour `rev_hour` produces a one-cycle `hour_dec` pulse in the cycle after the tick. `dst_active` is cleared in the same cycle.
- R4: While `dst_active` is 0, a match of the reverse point (such as the repeated hour after falling back) produces no `hour_dec`.
- R5: The day selector byte `*_wkday` has this layout: bit 7 is the priority, bits 6:4 the week of month and bits 3:0 the weekday. With the priority bit at 0, the day matches when `cur_date` equals the `*_date` byte, and the week and weekday fields have no effect.
- R6: With the priority bit at 1, the day matches when `cur_dow` equals bits 3:0 and the week of month, computed as (date-1)/7+1, equals bits 6:4.
- R7: A week value of 5 matches the last occurrence of the weekday in the month, meaning date+7 exceeds the month length. February has 29 days when the binary value of the BCD year is divisible by 4.
- R8: A transition fires only if, while enabled, a tick was seen on its day at minute 00 of an hour below the transition hour. Enabling later than that, or having the point already fire, leaves it unarmed.
- R9: When `fwd_month[7]` is 0, `dst_active` is 0 from the next cycle on and no adjust pulse is issued.
- R10: A month field of 00h never matches a calendar month. For the forward point the month field is `fwd_month[6:0]`; for the reverse point it is the whole `rev_month` byte.
- R11: Adjust pulses occur only in the cycle after a tick, and only when the ticked minute is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle strobe: calendar fields hold a new time |
| cur_year | input | 8 | Current year, BCD 00-99 |
| cur_month | input | 8 | Current month, BCD 01-12 |
| cur_date | input | 8 | Current date, BCD 01-31 |
| cur_dow | input | 3 | Current weekday, 0-6 |
| cur_hour | input | 8 | Current hour, BCD 00-23 |
| cur_min | input | 8 | Current minute, BCD 00-59 |
| fwd_month | input | 8 | Bit 7 master enable, bits 6:0 forward month BCD |
| fwd_wkday | input | 8 | Forward day selector (priority, week, weekday) |
| fwd_date | input | 8 | Forward date, BCD |
| fwd_hour | input | 8 | Forward hour, BCD |
| rev_month | input | 8 | Reverse month, BCD |
| rev_wkday | input | 8 | Reverse day selector (priority, week, weekday) |
| rev_date | input | 8 | Reverse date, BCD |
| rev_hour | input | 8 | Reverse hour, BCD |
| hour_inc | output | 1 | One-cycle command: advance hour by one |
| hour_dec | output | 1 | One-cycle command: move hour back by one |
| dst_active | output | 1 | Daylight saving adjustment in effect |

## Verification
The assertions assume the calendar inputs are legal BCD, the date lies within the length of the current month, and the weekday stays in 0-6. The week-range and last-occurrence properties depend on these limits. The stimulus keeps to them: every random calendar value is drawn as a binary number in range and then converted to BCD, and the date is bounded by a month length the bench computes itself. Control bytes are drawn only from legal field values, so any mismatch traces to decision logic and not to malformed inputs.

// File: rtl/dst_pkg.sv
package dst_pkg;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned DOW_W      = 3;
  localparam int unsigned WEEK_W     = 3;
  localparam int unsigned SEL_DOW_W  = 4;
  localparam int unsigned BIN_W      = 7;
  localparam int unsigned MDAY_W     = 5;
  localparam int unsigned LAST_WEEK  = 5;
  localparam int unsigned NUM_PTS    = 2;
  localparam int unsigned PT_FWD     = 0;
  localparam int unsigned PT_REV     = 1;
  localparam int unsigned RST_STAGES = 2;

  typedef struct packed {
    logic [BYTE_W-1:0]    month;
    logic                 by_week;
    logic [WEEK_W-1:0]    week;
    logic [SEL_DOW_W-1:0] dow;
    logic [BYTE_W-1:0]    date;
    logic [BYTE_W-1:0]    hour;
  } dst_point_t;

  function automatic logic [BIN_W-1:0] bcd_to_bin(input logic [BYTE_W-1:0] b);
    return BIN_W'(b[7:4]) * BIN_W'(10) + BIN_W'(b[3:0]);
  endfunction

  function automatic logic [MDAY_W-1:0] days_in_month(input logic [BIN_W-1:0] mon,
                                                      input logic leap);
    logic [MDAY_W-1:0] n;
    case (mon)
      BIN_W'(2):  n = leap ? MDAY_W'(29) : MDAY_W'(28);
      BIN_W'(4),
      BIN_W'(6),
      BIN_W'(9),
      BIN_W'(11): n = MDAY_W'(30);
      default:    n = MDAY_W'(31);
    endcase
    return n;
  endfunction

  function automatic dst_point_t make_point(input logic [BYTE_W-1:0] mon,
                                            input logic [BYTE_W-1:0] sel,
                                            input logic [BYTE_W-1:0] dat,
                                            input logic [BYTE_W-1:0] hr);
    dst_point_t p;
    p.month   = mon;
    p.by_week = sel[7];
    p.week    = sel[6:4];
    p.dow     = sel[3:0];
    p.date    = dat;
    p.hour    = hr;
    return p;
  endfunction

endpackage

// File: rtl/dst_week_calc.sv
module dst_week_calc
  import dst_pkg::*;
#(
  parameter int unsigned DAYS_PER_WEEK = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] cur_year,
  input  logic [BYTE_W-1:0] cur_month,
  input  logic [BYTE_W-1:0] cur_date,
  output logic [WEEK_W-1:0] week_idx,
  output logic              is_last
);

  localparam logic [BIN_W-1:0] WK_LEN = BIN_W'(DAYS_PER_WEEK);

  logic [BIN_W-1:0]  date_bin;
  logic [BIN_W-1:0]  mon_bin;
  logic [BIN_W-1:0]  year_bin;
  logic              leap;
  logic [MDAY_W-1:0] mdays;
  logic [BIN_W-1:0]  date_m1;
  logic [BIN_W:0]    reach;

  always_comb begin
    date_bin = bcd_to_bin(cur_date);
    mon_bin  = bcd_to_bin(cur_month);
    year_bin = bcd_to_bin(cur_year);
    leap     = (year_bin % BIN_W'(4)) == '0;
    mdays    = days_in_month(mon_bin, leap);
    date_m1  = date_bin - BIN_W'(1);
    week_idx = WEEK_W'((date_m1 / WK_LEN) + BIN_W'(1));
    reach    = {1'b0, date_bin} + {1'b0, WK_LEN};
    is_last  = reach > (BIN_W+1)'(mdays);
  end

  // R6: a legal date always lands in week 1..5
  p_week_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (date_bin >= BIN_W'(1) && date_bin <= BIN_W'(31))
      |-> (week_idx >= WEEK_W'(1) && week_idx <= WEEK_W'(LAST_WEEK)));

  // R7: the fifth occurrence of a weekday is always its last one
  p_fifth_is_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (date_bin >= BIN_W'(1) && date_bin <= BIN_W'(mdays) && week_idx == WEEK_W'(LAST_WEEK))
      |-> is_last);

endmodule

// File: rtl/dst_point_match.sv
module dst_point_match
  import dst_pkg::*;
(
  input  dst_point_t        pt,
  input  logic [BYTE_W-1:0] cur_month,
  input  logic [BYTE_W-1:0] cur_date,
  input  logic [DOW_W-1:0]  cur_dow,
  input  logic [BYTE_W-1:0] cur_hour,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [WEEK_W-1:0] week_idx,
  input  logic              is_last,
  output logic              day_hit,
  output logic              at_hour,
  output logic              before_hour
);

  logic month_hit;
  logic week_hit;
  logic wkday_hit;
  logic date_hit;
  logic top_of_hour;

  always_comb begin
    month_hit   = cur_month == pt.month;
    week_hit    = (week_idx == pt.week) ||
                  ((pt.week == WEEK_W'(LAST_WEEK)) && is_last);
    wkday_hit   = (pt.dow == SEL_DOW_W'(cur_dow)) && week_hit;
    date_hit    = cur_date == pt.date;
    day_hit     = month_hit && (pt.by_week ? wkday_hit : date_hit);
    top_of_hour = cur_min == '0;
    at_hour     = top_of_hour && (cur_hour == pt.hour);
    before_hour = top_of_hour && (cur_hour < pt.hour);
  end

endmodule

// File: rtl/dst_ctrl.sv
module dst_ctrl
  import dst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic fwd_day,
  input  logic fwd_at,
  input  logic fwd_before,
  input  logic rev_day,
  input  logic rev_at,
  input  logic rev_before,
  output logic hour_inc,
  output logic hour_dec,
  output logic dst_active
);

  logic arm_fwd_q, arm_fwd_d;
  logic arm_rev_q, arm_rev_d;
  logic active_q,  active_d;
  logic inc_q,     inc_d;
  logic dec_q,     dec_d;
  logic fire_fwd,  fire_rev;
  logic state_en;

  // next-state logic
  always_comb begin
    fire_fwd  = tick && enable && arm_fwd_q && !active_q && fwd_day && fwd_at;
    fire_rev  = tick && enable && arm_rev_q &&  active_q && rev_day && rev_at;
    state_en  = tick || !enable;
    arm_fwd_d = arm_fwd_q;
    arm_rev_d = arm_rev_q;
    active_d  = active_q;
    if (!enable) begin
      arm_fwd_d = 1'b0;
      arm_rev_d = 1'b0;
      active_d  = 1'b0;
    end else begin
      if (fire_fwd)                    arm_fwd_d = 1'b0;
      else if (fwd_day && fwd_before)  arm_fwd_d = 1'b1;
      if (fire_rev)                    arm_rev_d = 1'b0;
      else if (rev_day && rev_before)  arm_rev_d = 1'b1;
      if (fire_fwd)      active_d = 1'b1;
      else if (fire_rev) active_d = 1'b0;
    end
    inc_d = fire_fwd;
    dec_d = fire_rev;
  end

  // state registers, updated on a tick or while disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_fwd_q <= 1'b0;
      arm_rev_q <= 1'b0;
      active_q  <= 1'b0;
    end else if (state_en) begin
      arm_fwd_q <= arm_fwd_d;
      arm_rev_q <= arm_rev_d;
      active_q  <= active_d;
    end
  end

  // command pulse registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= 1'b0;
      dec_q <= 1'b0;
    end else begin
      inc_q <= inc_d;
      dec_q <= dec_d;
    end
  end

  assign hour_inc   = inc_q;
  assign hour_dec   = dec_q;
  assign dst_active = active_q;

  p_inc_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hour_inc |-> $past(tick));

  p_dec_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hour_dec |-> $past(tick));

  p_one_direction_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hour_inc, hour_dec}));

  p_inc_sets_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hour_inc |-> (dst_active && !$past(dst_active)));

  p_status_rises_by_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dst_active) |-> hour_inc);

  p_no_double_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hour_dec |-> ($past(dst_active) && !dst_active));

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!dst_active && !hour_inc && !hour_dec));

endmodule

// File: rtl/dst_adjuster.sv
module dst_adjuster
  import dst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [BYTE_W-1:0] cur_year,
  input  logic [BYTE_W-1:0] cur_month,
  input  logic [BYTE_W-1:0] cur_date,
  input  logic [DOW_W-1:0]  cur_dow,
  input  logic [BYTE_W-1:0] cur_hour,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [BYTE_W-1:0] fwd_month,
  input  logic [BYTE_W-1:0] fwd_wkday,
  input  logic [BYTE_W-1:0] fwd_date,
  input  logic [BYTE_W-1:0] fwd_hour,
  input  logic [BYTE_W-1:0] rev_month,
  input  logic [BYTE_W-1:0] rev_wkday,
  input  logic [BYTE_W-1:0] rev_date,
  input  logic [BYTE_W-1:0] rev_hour,
  output logic              hour_inc,
  output logic              hour_dec,
  output logic              dst_active
);

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_int;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[RST_STAGES-1];

  logic              master_en;
  logic [WEEK_W-1:0] week_idx;
  logic              is_last;
  dst_point_t        pts [NUM_PTS];
  logic [NUM_PTS-1:0] day_hit;
  logic [NUM_PTS-1:0] at_hour;
  logic [NUM_PTS-1:0] before_hour;

  assign master_en    = fwd_month[7];
  assign pts[PT_FWD]  = make_point({1'b0, fwd_month[6:0]}, fwd_wkday, fwd_date, fwd_hour);
  assign pts[PT_REV]  = make_point(rev_month, rev_wkday, rev_date, rev_hour);

  dst_week_calc u_week (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cur_year  (cur_year),
    .cur_month (cur_month),
    .cur_date  (cur_date),
    .week_idx  (week_idx),
    .is_last   (is_last)
  );

  for (genvar g = 0; g < NUM_PTS; g++) begin : g_point
    dst_point_match u_match (
      .pt          (pts[g]),
      .cur_month   (cur_month),
      .cur_date    (cur_date),
      .cur_dow     (cur_dow),
      .cur_hour    (cur_hour),
      .cur_min     (cur_min),
      .week_idx    (week_idx),
      .is_last     (is_last),
      .day_hit     (day_hit[g]),
      .at_hour     (at_hour[g]),
      .before_hour (before_hour[g])
    );
  end

  dst_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick       (tick),
    .enable     (master_en),
    .fwd_day    (day_hit[PT_FWD]),
    .fwd_at     (at_hour[PT_FWD]),
    .fwd_before (before_hour[PT_FWD]),
    .rev_day    (day_hit[PT_REV]),
    .rev_at     (at_hour[PT_REV]),
    .rev_before (before_hour[PT_REV]),
    .hour_inc   (hour_inc),
    .hour_dec   (hour_dec),
    .dst_active (dst_active)
  );

  // R10: the forward month field 00h can never be the calendar month
  p_zero_month_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (fwd_month[6:0] == '0 && cur_month != '0) |-> !day_hit[PT_FWD]);

endmodule

// File: tb/dst_adjuster_test.sv
module dst_adjuster_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam int RAND_STEPS = 4000;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic [7:0] cur_year, cur_month, cur_date, cur_hour, cur_min;
  logic [2:0] cur_dow;
  logic [7:0] fwd_month, fwd_wkday, fwd_date, fwd_hour;
  logic [7:0] rev_month, rev_wkday, rev_date, rev_hour;
  logic       hour_inc, hour_dec, dst_active;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bit m_armf, m_armr, m_act, m_inc, m_dec;

  dst_adjuster uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_year(cur_year), .cur_month(cur_month), .cur_date(cur_date),
    .cur_dow(cur_dow), .cur_hour(cur_hour), .cur_min(cur_min),
    .fwd_month(fwd_month), .fwd_wkday(fwd_wkday), .fwd_date(fwd_date), .fwd_hour(fwd_hour),
    .rev_month(rev_month), .rev_wkday(rev_wkday), .rev_date(rev_date), .rev_hour(rev_hour),
    .hour_inc(hour_inc), .hour_dec(hour_dec), .dst_active(dst_active)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  // expected day match from the requirement text (R5, R6, R7, R10)
  function automatic bit day_ok(input logic [7:0] mon, input logic [7:0] sel,
                                input logic [7:0] dat);
    int d, wk;
    bit last;
    if (mon != cur_month) return 0;
    if (!sel[7]) return dat == cur_date;
    d    = b2i(cur_date);
    wk   = (d - 1) / 7 + 1;
    last = (d + 7) > mdays(b2i(cur_month), b2i(cur_year));
    return (sel[3:0] == {1'b0, cur_dow}) &&
           ((int'(sel[6:4]) == wk) || (sel[6:4] == 3'd5 && last));
  endfunction

  function automatic void model_update();
    bit en, fd, rd, zero, ff, fr;
    en   = fwd_month[7];
    fd   = day_ok({1'b0, fwd_month[6:0]}, fwd_wkday, fwd_date);
    rd   = day_ok(rev_month, rev_wkday, rev_date);
    zero = cur_min == 8'h00;
    ff   = tick && en && m_armf && !m_act && fd && zero && cur_hour == fwd_hour;
    fr   = tick && en && m_armr &&  m_act && rd && zero && cur_hour == rev_hour;
    m_inc = ff;
    m_dec = fr;
    if (!en) begin
      m_armf = 0; m_armr = 0; m_act = 0;
    end else if (tick) begin
      if (ff) m_armf = 0;
      else if (fd && zero && cur_hour < fwd_hour) m_armf = 1;
      if (fr) m_armr = 0;
      else if (rd && zero && cur_hour < rev_hour) m_armr = 1;
      if (ff) m_act = 1;
      else if (fr) m_act = 0;
    end
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    model_update();
  endtask

  task automatic chk(input string tag, input bit ei, input bit ed, input bit ea);
    checks++;
    if (hour_inc !== ei || hour_dec !== ed || dst_active !== ea) begin
      errors++;
      $display("FAIL %s: inc/dec/active got %b%b%b expected %b%b%b",
               tag, hour_inc, hour_dec, dst_active, ei, ed, ea);
    end
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int dw,
                          input int h, input int mi, input bit tk);
    cur_year  = i2b(y);
    cur_month = i2b(mo);
    cur_date  = i2b(d);
    cur_dow   = 3'(dw);
    cur_hour  = i2b(h);
    cur_min   = i2b(mi);
    tick      = tk;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: got no finish, expected finish before %0d cycles", WATCHDOG);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240310));
    rst_n = 0;
    set_time(24, 1, 1, 1, 0, 0, 0);
    fwd_month = 8'h83; fwd_wkday = 8'hA0; fwd_date = 8'h00; fwd_hour = 8'h02;
    rev_month = 8'h11; rev_wkday = 8'h90; rev_date = 8'h00; rev_hour = 8'h02;
    m_armf = 0; m_armr = 0; m_act = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 0, 0, 0);
    rst_n = 1;
    repeat (3) step();
    chk("R1 after release", 0, 0, 0);

    // R6 negative: first Sunday of March is not the second
    set_time(24, 3, 3, 0, 0, 0, 1); step();
    set_time(24, 3, 3, 0, 2, 0, 1); step();
    chk("R6 wrong week", 0, 0, 0);

    // R2/R6/R8/R11: second Sunday of March 2024, 02:00
    set_time(24, 3, 10, 0, 1, 0, 1); step();
    chk("R8 arm tick", 0, 0, 0);
    set_time(24, 3, 10, 0, 2, 0, 0); step();
    chk("R11 no tick", 0, 0, 0);
    set_time(24, 3, 10, 0, 2, 0, 1); step();
    chk("R2 forward", 1, 0, 1);
    tick = 0; step();
    chk("R2 single pulse", 0, 0, 1);
    set_time(24, 3, 10, 0, 3, 0, 1); step();
    chk("R6 after jump", 0, 0, 1);

    // R3: first Sunday of November
    set_time(24, 11, 3, 0, 1, 0, 1); step();
    chk("R3 arm", 0, 0, 1);
    set_time(24, 11, 3, 0, 2, 0, 1); step();
    chk("R3 reverse", 0, 1, 0);
    tick = 0; step();
    chk("R3 single pulse", 0, 0, 0);
    // R4: repeated hour
    set_time(24, 11, 3, 0, 1, 0, 1); step();
    set_time(24, 11, 3, 0, 2, 0, 1); step();
    chk("R4 repeated hour", 0, 0, 0);

    // R5: date mode, week and weekday fields disagree on purpose
    fwd_month = 8'h84; fwd_wkday = 8'h20; fwd_date = 8'h15;
    set_time(24, 4, 15, 3, 0, 0, 1); step();
    set_time(24, 4, 15, 3, 2, 0, 1); step();
    chk("R5 date mode", 1, 0, 1);

    // R9: disable clears status, no pulses while disabled
    fwd_month = 8'h04; tick = 0; step();
    chk("R9 clear", 0, 0, 0);
    set_time(24, 4, 15, 3, 0, 0, 1); step();
    set_time(24, 4, 15, 3, 2, 0, 1); step();
    chk("R9 disabled match", 0, 0, 0);

    // R8: enabled too late
    set_time(24, 4, 15, 3, 1, 0, 1); step();
    fwd_month = 8'h84;
    set_time(24, 4, 15, 3, 1, 30, 1); step();
    set_time(24, 4, 15, 3, 2, 0, 1); step();
    chk("R8 late enable", 0, 0, 0);

    // R7: last Saturday of February, leap and non-leap
    fwd_month = 8'h82; fwd_wkday = 8'hD6; fwd_date = 8'h00;
    set_time(24, 2, 22, 6, 1, 0, 1); step();
    set_time(24, 2, 22, 6, 2, 0, 1); step();
    chk("R7 leap not last", 0, 0, 0);
    set_time(25, 2, 22, 6, 1, 0, 1); step();
    set_time(25, 2, 22, 6, 2, 0, 1); step();
    chk("R7 non-leap last", 1, 0, 1);
    fwd_month = 8'h02; tick = 0; step();
    chk("R9 clear again", 0, 0, 0);

    // R10: month 00h
    fwd_month = 8'h80; fwd_wkday = 8'h00; fwd_date = 8'h01;
    set_time(24, 1, 1, 1, 0, 0, 1); step();
    set_time(24, 1, 1, 1, 2, 0, 1); step();
    chk("R10 month zero", 0, 0, 0);

    // R11: minute must be 00
    fwd_month = 8'h84; fwd_date = 8'h15;
    set_time(24, 4, 15, 3, 0, 0, 1); step();
    set_time(24, 4, 15, 3, 2, 1, 1); step();
    chk("R11 minute 01", 0, 0, 0);
    set_time(24, 4, 15, 3, 2, 0, 1); step();
    chk("R11 minute 00", 1, 0, 1);

    // constrained random against the bench model
    for (int i = 0; i < RAND_STEPS; i++) begin
      int y, mo, d, h;
      if (i % 200 == 0) begin
        fwd_month = {($urandom % 10) != 0, i2b(1 + $urandom % 12)[6:0]};
        fwd_wkday = {1'($urandom), 3'(1 + $urandom % 5), 4'($urandom % 7)};
        fwd_date  = i2b(1 + $urandom % 28);
        fwd_hour  = i2b(1 + $urandom % 5);
        rev_month = i2b(1 + $urandom % 12);
        rev_wkday = {1'($urandom), 3'(1 + $urandom % 5), 4'($urandom % 7)};
        rev_date  = i2b(1 + $urandom % 28);
        rev_hour  = i2b(1 + $urandom % 5);
      end
      y  = 20 + $urandom % 8;
      case ($urandom % 3)
        0:       mo = b2i({1'b0, fwd_month[6:0]});
        1:       mo = b2i(rev_month);
        default: mo = 1 + $urandom % 12;
      endcase
      d = ($urandom % 2) ? b2i((mo == b2i(rev_month)) ? rev_date : fwd_date)
                         : 1 + $urandom % mdays(mo, y);
      if (d > mdays(mo, y)) d = mdays(mo, y);
      h = $urandom % 7;
      set_time(y, mo, d, $urandom % 7, h, ($urandom % 10 < 7) ? 0 : 1 + $urandom % 59,
               ($urandom % 10) < 6);
      step();
      chk("R2/R3/R4 random", m_inc, m_dec, m_act);
    end

    done = 1;
    finish_run();
  end

endmodule